// File: doc/BRIEF.md
# Phase-Doubler Power-Up and Calibration Sequencer

This block decides when the two three-level drive outputs of a current-balancing phase doubler are floating, parked at the middle level, or allowed to follow the incoming PWM. A session begins when the supply-good flag and the enable input are high together. The outputs then stay floating for a power-on delay, sit at the middle level while calibration runs, and release the ready pad when calibration completes. From that point the outputs follow the PWM while the driver-on input is high and sit at the middle level while it is low.

The block arms itself once enable and driver-on have been seen high together. An armed session ends only when both inputs are low together, or when the supply flag drops. An unarmed session ends as soon as enable falls. Both delays are parameterised clock counts. The steering logic reads the selector, and the open-drain pad is driven from the active-low ready output.

Top module: `dbl_seq`

## Requirements
- R1: A clock edge that samples `supply_ok` low ends any session and clears the arm state. After that edge `out_mode` is 2'b00, `rdy_pull` is 1 and `cal_busy` is 0.
- R2: Call the first edge that samples `supply_ok` and `en_i` both high, while no session is running, edge 0. `out_mode` stays 2'b00 (floating) until edge `POR_CYCLES`, and from that edge on it reads 2'b01 (middle level).
- R3: `cal_busy` is 1 and `rdy_pull` is 1 from edge 0 until edge `CAL_CYCLES`. At edge `CAL_CYCLES` both go to 0, on the same edge.
- R4: Once calibration is done, `out_mode` is 2'b10 (follow PWM) while `drvon_i` is high and 2'b01 while it is low. This is combinational on `drvon_i`. Before calibration is done, 2'b10 never appears.
- R5: In an unarmed session, an edge that samples `en_i` low ends the session. `out_mode` returns to 2'b00 and `rdy_pull` to 1, whatever `drvon_i` is.
- R6: An edge that samples `en_i` and `drvon_i` both high during a session (edge 0 included) arms it. An armed session survives either input alone going low.
- R7: An armed session ends at an edge that samples `en_i` and `drvon_i` both low. A later enable then replays the whole power-on and calibration sequence of R2 and R3.
- R8: A session started after a supply loss is unarmed, even if the session before it was armed.
- R9: While `rst_n` is low, `out_mode` is 2'b00, `rdy_pull` is 1 and `cal_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| en_i | input | 1 | Enable input |
| drvon_i | input | 1 | Driver-on input |
| out_mode | output | 2 | 00 floating, 01 middle level, 10 follow PWM |
| rdy_pull | output | 1 | 1 pulls the ready pad low |
| cal_busy | output | 1 | Calibration period running |

## Verification
The shutdown decision can land on the same edge as the end of calibration. If it does, the outputs must go floating and the ready pad must stay pulled, rather than following the PWM for one cycle. The bench provokes this by lowering enable in an unarmed session so that the edge which would complete calibration samples it low. A bench model that works purely from session timing judges the result. Random toggling of supply, enable and driver-on also drives arming, supply loss and session start against one another on shared edges.

// File: rtl/dbl_seq.sv
module dbl_seq #(
  parameter int POR_CYCLES = 17,
  parameter int CAL_CYCLES = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en_i,
  input  logic       drvon_i,
  output logic [1:0] out_mode,
  output logic       rdy_pull,
  output logic       cal_busy
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [1:0] M_HIZ = 2'b00;
  localparam logic [1:0] M_MID = 2'b01;
  localparam logic [1:0] M_FOL = 2'b10;

  logic          active, armed, por_done, cal_done;
  logic [CW-1:0] cnt;

  wire both_hi = en_i && drvon_i;
  wire start   = !active && supply_ok && en_i;
  wire stop    = active && (!supply_ok || (armed ? (!en_i && !drvon_i) : !en_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      por_done <= 1'b0;
      cal_done <= 1'b0;
    end else if (stop || (!active && !start)) begin
      active   <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      por_done <= 1'b0;
      cal_done <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      armed    <= both_hi;
      cnt      <= '0;
      por_done <= 1'b0;
      cal_done <= 1'b0;
    end else begin
      if (both_hi) armed <= 1'b1;
      if (!cal_done) cnt <= cnt + 1'b1;
      if (cnt == CW'(POR_CYCLES - 1)) por_done <= 1'b1;
      if (cnt == CW'(CAL_CYCLES - 1)) cal_done <= 1'b1;
    end
  end

  assign out_mode = (!active || !por_done) ? M_HIZ :
                    (cal_done && drvon_i)   ? M_FOL : M_MID;
  assign rdy_pull = !cal_done;
  assign cal_busy = active && !cal_done;

  // R1
  vok_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (out_mode == M_HIZ && rdy_pull && !cal_busy));

  // R3
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_pull) |-> ($past(cal_busy) && !cal_busy));

  // R4
  follow_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == M_FOL) |-> (!rdy_pull && drvon_i));

  // R5
  unarmed_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !armed && !en_i) |=> (out_mode == M_HIZ && rdy_pull));

  // R6
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && armed && supply_ok && (en_i || drvon_i)) |=> active);

  // R7
  armed_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && armed && !en_i && !drvon_i) |=> (!active && rdy_pull));
endmodule

// File: tb/dbl_seq_tb.sv
module dbl_seq_tb;
  localparam int POR = 17;
  localparam int CAL = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vok = 1'b0, en = 1'b0, drv = 1'b0;
  logic [1:0] mode;
  logic pull, busy;

  int checks = 0, fails = 0, cyc = 0;
  bit m_act, m_arm;
  int m_n;

  always #2.5 clk = ~clk;

  dbl_seq #(.POR_CYCLES(POR), .CAL_CYCLES(CAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(vok), .en_i(en), .drvon_i(drv),
    .out_mode(mode), .rdy_pull(pull), .cal_busy(busy));

  // session-timing model of the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_arm <= 0; m_n <= 0;
    end else if (m_act) begin
      if (!vok || (m_arm ? (!en && !drv) : !en)) begin
        m_act <= 0; m_arm <= 0;
      end else begin
        m_n <= (m_n < CAL) ? m_n + 1 : CAL;
        if (en && drv) m_arm <= 1;
      end
    end else begin
      m_arm <= 0;
      if (vok && en) begin m_act <= 1; m_n <= 0; m_arm <= en && drv; end
    end
  end

  function automatic logic [3:0] expect_out();
    if (!m_act || m_n < POR) return {2'b00, 1'b1, m_act};
    if (m_n < CAL) return {2'b01, 1'b1, 1'b1};
    return {(drv ? 2'b10 : 2'b01), 1'b0, 1'b0};
  endfunction

  function automatic string auto_tag();
    if (!m_act) return "R5";
    if (m_n < POR) return "R2";
    if (m_n < CAL) return "R3";
    return "R4";
  endfunction

  task automatic check_out(string tag);
    logic [3:0] e;
    e = expect_out();
    checks++;
    if ({mode, pull, busy} !== e) begin
      fails++;
      $display("FAIL %s mode/pull/busy actual=%b expected=%b", tag, {mode, pull, busy}, e);
    end
  endtask

  task automatic tick(string tag = "");
    @(posedge clk);
    @(negedge clk);
    check_out(tag == "" ? auto_tag() : tag);
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    check_out("R9");
    vok = 1; en = 1; drv = 1;
    @(negedge clk);
    check_out("R9");
    rst_n = 1;
    // R2 / R3 boundaries: armed session from edge 0
    ticks(POR);
    tick("R2");
    ticks(CAL - POR - 2);
    tick("R3");
    tick("R4");
    // R6: drop one input at a time, session survives
    en = 0; ticks(3); tick("R6");
    en = 1; drv = 0; ticks(3); tick("R6");
    // R7: both low ends it, then a full replay
    en = 0; tick("R7");
    en = 1; drv = 1; ticks(POR); tick("R7"); ticks(CAL - POR); tick("R7");
    // R8: supply loss clears arming; enable alone then ends the new session
    vok = 0; tick("R1");
    vok = 1; en = 1; drv = 0; ticks(5);
    en = 0; drv = 1; tick("R8");
    // R4 with driver-on low, then R5
    en = 1; drv = 0; ticks(CAL + 2); tick("R4");
    drv = 1; tick("R4");
    drv = 0; en = 0; tick("R5");
    // shutdown on the very edge calibration would complete
    en = 1; ticks(CAL);
    en = 0; tick("R5");
    // R1: supply loss during calibration
    en = 1; ticks(POR + 4);
    vok = 0; tick("R1");
    vok = 1;
    // random phase
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 400 == 0) vok = !vok;
      if ($urandom % 40 == 0) en = !en;
      if ($urandom % 30 == 0) drv = !drv;
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule